// File: doc/BRIEF.md
# Snooping Coherence Line Controller

This block tracks coherence for a small direct-mapped snooping cache. For each line it keeps an address tag and a four-state coherence code (Modified, Exclusive, Shared, Invalid). It accepts read and write requests from its processor, decides whether they hit, and on a miss or on a write to a shared copy it places a request on the shared bus. It also watches requests that other agents place on that bus. When its own copy is involved it answers with a data-supply strobe and, for dirty data, a write-back strobe, and it downgrades or invalidates the line.

Only one bus transaction is outstanding at a time. While a read fill, a write fill or an upgrade is in flight, the line sits in a transient state: read pending, write pending or upgrade pending. The processor port then stalls. An invalidating snoop that hits a line in the read-pending or upgrade-pending state is remembered. It takes effect when the pending transaction finishes. The bus model around the block returns fills with a shared-line indication and signals when all invalidation acknowledgments have been collected.

Top module: `coh_line_ctrl`

## Requirements
- R1: After reset every line is Invalid, `cpu_req_ready` is high, and `cpu_resp_valid`, `bus_req_valid`, `snp_supply`, `snp_flush` and `wb_valid` are low.
- R2: A read that misses puts a read request (op code 0) with the request address on the bus one cycle after acceptance. One cycle after the fill, the response reports state code 2 (Exclusive) if `bus_fill_shared` was low, or 1 (Shared) if it was high.
- R3: A write that misses issues a read-for-ownership (op code 1). One cycle after the fill, the response reports state code 3 (Modified).
- R4: A write that hits a Shared line issues an upgrade (op code 2) and stalls. One cycle after `bus_ack_done`, the response reports Modified.
- R5: A read hit in Modified, Exclusive or Shared responds one cycle after acceptance with the line's state code and no bus request. A write hit on an Exclusive or Modified line does the same, reports Modified, and issues no bus request.
- R6: A snooped read (op code 0) to a Modified line raises `snp_supply` and `snp_flush`. To an Exclusive line it raises `snp_supply` only. Both lines become Shared. To a Shared line it changes nothing. Snoop strobes appear one cycle after the snoop.
- R7: A snooped read-for-ownership (op code 1) supplies data from a Modified line (with flush) or an Exclusive line (without flush). It leaves any valid line Invalid. A snooped upgrade (op code 2) invalidates a Shared line with no strobes.
- R8: A snoop whose tag differs from the stored one, or that targets an Invalid line or a line in the write-pending state, has no effect on state or strobes.
- R9: An invalidating snoop (op 1 or 2) to a line in the read-pending state raises no strobe. When the fill arrives, the read completes with response state code 0 and the line is left Invalid.
- R10: An invalidating snoop to a line in the upgrade-pending state is recorded. On `bus_ack_done` the controller issues a read-for-ownership for the same address instead of completing. The following fill completes the write as Modified.
- R11: `cpu_req_ready` is low while a transaction is pending and in any cycle with `snp_valid` high. A request held while not ready causes no bus request and no response.
- R12: A miss that replaces a Modified line with a different tag pulses `wb_valid` with the victim's address together with the new bus request. Exclusive or Shared victims are dropped without a write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | Processor line address |
| cpu_req_ready | output | 1 | Request accepted this cycle when high with valid |
| cpu_resp_valid | output | 1 | Request completed (one-cycle pulse) |
| cpu_resp_state | output | 3 | Line state code after completion |
| bus_req_valid | output | 1 | Bus request pulse |
| bus_req_op | output | 2 | 0 read, 1 read-for-ownership, 2 upgrade |
| bus_req_addr | output | ADDR_W | Bus request address |
| bus_fill_valid | input | 1 | Data returned for the pending read or read-for-ownership |
| bus_fill_shared | input | 1 | Another cache holds the line (sampled with the fill) |
| bus_ack_done | input | 1 | All invalidation acknowledgments for the upgrade received |
| snp_valid | input | 1 | Snooped request from another agent |
| snp_op | input | 2 | Snooped op code, same encoding as bus_req_op |
| snp_addr | input | ADDR_W | Snooped line address |
| snp_supply | output | 1 | This cache supplies the data |
| snp_flush | output | 1 | Dirty data is also written back to memory |
| wb_valid | output | 1 | Victim write-back pulse |
| wb_addr | output | ADDR_W | Victim line address |

## Verification
The hardest situations to reach are the recorded-invalidation cases. A snoop must land while a line sits between issuing its request and receiving its fill or acknowledgments. The bench reaches them by holding back the fill or acknowledgment after a miss or upgrade is issued, injecting the invalidating snoop in that gap, and only then completing the transaction. It then confirms the outcome from the ports: a response reporting Invalid followed by a fresh miss, or a second bus request of the ownership kind. Write-backs of dirty victims are produced the same way, by first building a Modified line through an upgrade and then missing on another tag that maps to the same index.

// File: rtl/coh_pkg.sv
package coh_pkg;

  typedef enum logic [2:0] {
    ST_I  = 3'd0,
    ST_S  = 3'd1,
    ST_E  = 3'd2,
    ST_M  = 3'd3,
    ST_IS = 3'd4,
    ST_IM = 3'd5,
    ST_SM = 3'd6
  } line_st_e;

  typedef enum logic [1:0] {
    OP_RD   = 2'd0,
    OP_RDX  = 2'd1,
    OP_UPGR = 2'd2
  } bus_op_e;

  function automatic logic st_valid(line_st_e s);
    return (s == ST_S) || (s == ST_E) || (s == ST_M);
  endfunction

  function automatic logic st_transient(line_st_e s);
    return (s == ST_IS) || (s == ST_IM) || (s == ST_SM);
  endfunction

endpackage

// File: rtl/coh_line_store.sv
module coh_line_store
  import coh_pkg::*;
#(
  parameter int NUM_LINES = 4,
  parameter int IDX_W     = 2,
  parameter int TAG_W     = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_a_idx,
  output logic [TAG_W-1:0] rd_a_tag,
  output line_st_e         rd_a_st,
  input  logic [IDX_W-1:0] rd_b_idx,
  output logic [TAG_W-1:0] rd_b_tag,
  output line_st_e         rd_b_st,
  input  logic             wr_a_en,
  input  logic [IDX_W-1:0] wr_a_idx,
  input  logic [TAG_W-1:0] wr_a_tag,
  input  line_st_e         wr_a_st,
  input  logic             wr_b_en,
  input  logic [IDX_W-1:0] wr_b_idx,
  input  line_st_e         wr_b_st
);

  logic [TAG_W-1:0]     tag_q [NUM_LINES];
  line_st_e             st_q  [NUM_LINES];
  logic [NUM_LINES-1:0] pend_vec;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) begin
        st_q[g]  <= ST_I;
        tag_q[g] <= '0;
      end else if (wr_a_en && wr_a_idx == IDX_W'(g)) begin
        st_q[g]  <= wr_a_st;
        tag_q[g] <= wr_a_tag;
      end else if (wr_b_en && wr_b_idx == IDX_W'(g)) begin
        st_q[g]  <= wr_b_st;
      end
    end
    assign pend_vec[g] = st_transient(st_q[g]);
  end

  assign rd_a_tag = tag_q[rd_a_idx];
  assign rd_a_st  = st_q[rd_a_idx];
  assign rd_b_tag = tag_q[rd_b_idx];
  assign rd_b_st  = st_q[rd_b_idx];

  // R11: one outstanding transaction means at most one line in flight
  assert_single_pending_R11: assert property (@(posedge clk) disable iff (rst)
    $countones(pend_vec) <= 1);

endmodule

// File: rtl/coh_snoop_eval.sv
module coh_snoop_eval
  import coh_pkg::*;
(
  input  logic       snp_valid,
  input  logic [1:0] snp_op,
  input  logic       tag_hit,
  input  line_st_e   cur_st,
  output logic       st_we,
  output line_st_e   st_nxt,
  output logic       supply,
  output logic       flush,
  output logic       inval_pend
);

  bus_op_e op;
  logic    kills;

  assign op    = bus_op_e'(snp_op);
  assign kills = (op == OP_RDX) || (op == OP_UPGR);

  always_comb begin
    st_we      = 1'b0;
    st_nxt     = cur_st;
    supply     = 1'b0;
    flush      = 1'b0;
    inval_pend = 1'b0;
    if (snp_valid && tag_hit) begin
      case (cur_st)
        ST_M: begin
          if (op == OP_RD) begin
            supply = 1'b1; flush = 1'b1; st_we = 1'b1; st_nxt = ST_S;
          end else if (op == OP_RDX) begin
            supply = 1'b1; flush = 1'b1; st_we = 1'b1; st_nxt = ST_I;
          end
        end
        ST_E: begin
          if (op == OP_RD) begin
            supply = 1'b1; st_we = 1'b1; st_nxt = ST_S;
          end else if (op == OP_RDX) begin
            supply = 1'b1; st_we = 1'b1; st_nxt = ST_I;
          end
        end
        ST_S: begin
          if (kills) begin
            st_we = 1'b1; st_nxt = ST_I;
          end
        end
        ST_IS, ST_SM: inval_pend = kills;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/coh_txn_fsm.sv
module coh_txn_fsm
  import coh_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req_valid,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  output logic              cpu_req_ready,
  output logic              cpu_resp_valid,
  output logic [2:0]        cpu_resp_state,
  input  logic              snp_valid,
  input  logic              snp_inval_pend,
  input  logic              bus_fill_valid,
  input  logic              bus_fill_shared,
  input  logic              bus_ack_done,
  output logic              bus_req_valid,
  output logic [1:0]        bus_req_op,
  output logic [ADDR_W-1:0] bus_req_addr,
  output logic              wb_valid,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [IDX_W-1:0]  rd_idx,
  input  logic [TAG_W-1:0]  line_tag,
  input  line_st_e          line_st,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [TAG_W-1:0]  wr_tag,
  output line_st_e          wr_st
);

  logic              busy_q, busy_d;
  line_st_e          phase_q, phase_d;
  logic [IDX_W-1:0]  p_idx_q, p_idx_d;
  logic [TAG_W-1:0]  p_tag_q, p_tag_d;
  logic              kill_q, kill_d;

  logic              resp_d;
  logic [2:0]        resp_st_d;
  logic              issue_d;
  bus_op_e           issue_op_d;
  logic [ADDR_W-1:0] issue_addr_d;
  logic              wb_d;
  logic [ADDR_W-1:0] wb_addr_d;

  logic [IDX_W-1:0]  req_idx;
  logic [TAG_W-1:0]  req_tag;
  logic              accept, hit, kill_now, fill_done, ack_done;

  assign req_idx       = cpu_req_addr[IDX_W-1:0];
  assign req_tag       = cpu_req_addr[ADDR_W-1:IDX_W];
  assign rd_idx        = req_idx;
  assign cpu_req_ready = !busy_q && !snp_valid;
  assign accept        = cpu_req_valid && cpu_req_ready;
  assign hit           = (line_tag == req_tag) && st_valid(line_st);
  assign kill_now      = kill_q || snp_inval_pend;
  assign fill_done     = busy_q && bus_fill_valid && (phase_q == ST_IS || phase_q == ST_IM);
  assign ack_done      = busy_q && bus_ack_done && (phase_q == ST_SM);

  always_comb begin
    busy_d       = busy_q;
    phase_d      = phase_q;
    p_idx_d      = p_idx_q;
    p_tag_d      = p_tag_q;
    kill_d       = kill_q || (busy_q && snp_inval_pend);
    wr_en        = 1'b0;
    wr_idx       = p_idx_q;
    wr_tag       = p_tag_q;
    wr_st        = ST_I;
    resp_d       = 1'b0;
    resp_st_d    = 3'd0;
    issue_d      = 1'b0;
    issue_op_d   = OP_RD;
    issue_addr_d = {p_tag_q, p_idx_q};
    wb_d         = 1'b0;
    wb_addr_d    = {line_tag, req_idx};

    if (accept) begin
      wr_idx       = req_idx;
      wr_tag       = req_tag;
      issue_addr_d = cpu_req_addr;
      if (hit) begin
        if (cpu_req_write && line_st == ST_S) begin
          wr_en      = 1'b1;
          wr_st      = ST_SM;
          busy_d     = 1'b1;
          phase_d    = ST_SM;
          p_idx_d    = req_idx;
          p_tag_d    = req_tag;
          kill_d     = 1'b0;
          issue_d    = 1'b1;
          issue_op_d = OP_UPGR;
        end else if (cpu_req_write) begin
          wr_en     = 1'b1;
          wr_st     = ST_M;
          resp_d    = 1'b1;
          resp_st_d = 3'(ST_M);
        end else begin
          resp_d    = 1'b1;
          resp_st_d = 3'(line_st);
        end
      end else begin
        wb_d       = (line_st == ST_M);
        wr_en      = 1'b1;
        wr_st      = cpu_req_write ? ST_IM : ST_IS;
        busy_d     = 1'b1;
        phase_d    = cpu_req_write ? ST_IM : ST_IS;
        p_idx_d    = req_idx;
        p_tag_d    = req_tag;
        kill_d     = 1'b0;
        issue_d    = 1'b1;
        issue_op_d = cpu_req_write ? OP_RDX : OP_RD;
      end
    end else if (fill_done) begin
      busy_d = 1'b0;
      kill_d = 1'b0;
      wr_en  = 1'b1;
      resp_d = 1'b1;
      if (phase_q == ST_IS)
        wr_st = kill_now ? ST_I : (bus_fill_shared ? ST_S : ST_E);
      else
        wr_st = ST_M;
      resp_st_d = 3'(wr_st);
    end else if (ack_done) begin
      kill_d = 1'b0;
      wr_en  = 1'b1;
      if (kill_now) begin
        wr_st      = ST_IM;
        phase_d    = ST_IM;
        issue_d    = 1'b1;
        issue_op_d = OP_RDX;
      end else begin
        wr_st     = ST_M;
        busy_d    = 1'b0;
        resp_d    = 1'b1;
        resp_st_d = 3'(ST_M);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q         <= 1'b0;
      phase_q        <= ST_IS;
      p_idx_q        <= '0;
      p_tag_q        <= '0;
      kill_q         <= 1'b0;
      cpu_resp_valid <= 1'b0;
      cpu_resp_state <= 3'd0;
      bus_req_valid  <= 1'b0;
      bus_req_op     <= 2'd0;
      bus_req_addr   <= '0;
      wb_valid       <= 1'b0;
      wb_addr        <= '0;
    end else begin
      busy_q         <= busy_d;
      phase_q        <= phase_d;
      p_idx_q        <= p_idx_d;
      p_tag_q        <= p_tag_d;
      kill_q         <= kill_d;
      cpu_resp_valid <= resp_d;
      cpu_resp_state <= resp_st_d;
      bus_req_valid  <= issue_d;
      bus_req_op     <= 2'(issue_op_d);
      bus_req_addr   <= issue_addr_d;
      wb_valid       <= wb_d;
      wb_addr        <= wb_addr_d;
    end
  end

  // R5: a response must follow an accepted request or a completion input
  assert_resp_cause_R5: assert property (@(posedge clk) disable iff (rst)
    cpu_resp_valid |-> ($past(cpu_req_valid && cpu_req_ready) || $past(bus_fill_valid)
                        || $past(bus_ack_done)));

  // R4: an upgrade only follows an accepted write
  assert_upgr_cause_R4: assert property (@(posedge clk) disable iff (rst)
    (bus_req_valid && bus_req_op == 2'(OP_UPGR)) |-> $past(cpu_req_valid && cpu_req_write));

  // R2: a plain bus read only follows an accepted processor read
  assert_rd_cause_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_req_valid && bus_req_op == 2'(OP_RD)) |-> $past(cpu_req_valid && !cpu_req_write));

  // R12: a victim write-back rides with a miss request
  assert_wb_with_miss_R12: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> (bus_req_valid && bus_req_op != 2'(OP_UPGR)));

endmodule

// File: rtl/coh_line_ctrl.sv
module coh_line_ctrl
  import coh_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int NUM_LINES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req_valid,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  output logic              cpu_req_ready,
  output logic              cpu_resp_valid,
  output logic [2:0]        cpu_resp_state,
  output logic              bus_req_valid,
  output logic [1:0]        bus_req_op,
  output logic [ADDR_W-1:0] bus_req_addr,
  input  logic              bus_fill_valid,
  input  logic              bus_fill_shared,
  input  logic              bus_ack_done,
  input  logic              snp_valid,
  input  logic [1:0]        snp_op,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_supply,
  output logic              snp_flush,
  output logic              wb_valid,
  output logic [ADDR_W-1:0] wb_addr
);

  localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0] a_idx, wa_idx;
  logic [TAG_W-1:0] a_tag, wa_tag, b_tag;
  line_st_e         a_st, b_st, wa_st, sn_st;
  logic             wa_en, sn_we, sn_supply, sn_flush, sn_pend;

  coh_line_store #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_store (
    .clk(clk), .rst(rst),
    .rd_a_idx(a_idx), .rd_a_tag(a_tag), .rd_a_st(a_st),
    .rd_b_idx(snp_addr[IDX_W-1:0]), .rd_b_tag(b_tag), .rd_b_st(b_st),
    .wr_a_en(wa_en), .wr_a_idx(wa_idx), .wr_a_tag(wa_tag), .wr_a_st(wa_st),
    .wr_b_en(sn_we), .wr_b_idx(snp_addr[IDX_W-1:0]), .wr_b_st(sn_st)
  );

  coh_snoop_eval u_snoop (
    .snp_valid(snp_valid), .snp_op(snp_op),
    .tag_hit(b_tag == snp_addr[ADDR_W-1:IDX_W]), .cur_st(b_st),
    .st_we(sn_we), .st_nxt(sn_st), .supply(sn_supply), .flush(sn_flush),
    .inval_pend(sn_pend)
  );

  coh_txn_fsm #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_fsm (
    .clk(clk), .rst(rst),
    .cpu_req_valid(cpu_req_valid), .cpu_req_write(cpu_req_write),
    .cpu_req_addr(cpu_req_addr), .cpu_req_ready(cpu_req_ready),
    .cpu_resp_valid(cpu_resp_valid), .cpu_resp_state(cpu_resp_state),
    .snp_valid(snp_valid), .snp_inval_pend(sn_pend),
    .bus_fill_valid(bus_fill_valid), .bus_fill_shared(bus_fill_shared),
    .bus_ack_done(bus_ack_done),
    .bus_req_valid(bus_req_valid), .bus_req_op(bus_req_op), .bus_req_addr(bus_req_addr),
    .wb_valid(wb_valid), .wb_addr(wb_addr),
    .rd_idx(a_idx), .line_tag(a_tag), .line_st(a_st),
    .wr_en(wa_en), .wr_idx(wa_idx), .wr_tag(wa_tag), .wr_st(wa_st)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      snp_supply <= 1'b0;
      snp_flush  <= 1'b0;
    end else begin
      snp_supply <= sn_supply;
      snp_flush  <= sn_flush;
    end
  end

  // R6: a flush never goes out without the data supply
  assert_flush_supply_R6: assert property (@(posedge clk) disable iff (rst)
    snp_flush |-> snp_supply);

  // R8: snoop strobes only answer an actual snoop
  assert_snoop_origin_R8: assert property (@(posedge clk) disable iff (rst)
    snp_supply |-> $past(snp_valid));

  // R11: a bus request means a pending transaction, so no acceptance
  assert_busy_stall_R11: assert property (@(posedge clk) disable iff (rst)
    bus_req_valid |-> !cpu_req_ready);

endmodule

// File: tb/coh_line_ctrl_tb.sv
module coh_line_ctrl_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cpu_req_valid = 0, cpu_req_write = 0;
  logic [7:0] cpu_req_addr = 0;
  logic       cpu_req_ready, cpu_resp_valid;
  logic [2:0] cpu_resp_state;
  logic       bus_req_valid;
  logic [1:0] bus_req_op;
  logic [7:0] bus_req_addr;
  logic       bus_fill_valid = 0, bus_fill_shared = 0, bus_ack_done = 0;
  logic       snp_valid = 0;
  logic [1:0] snp_op = 0;
  logic [7:0] snp_addr = 0;
  logic       snp_supply, snp_flush, wb_valid;
  logic [7:0] wb_addr;

  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  coh_line_ctrl #(.ADDR_W(8), .NUM_LINES(4)) u_dut (.*);

  function automatic logic [15:0] rd(logic [7:0] a); return {3'b100, 2'd0, 3'b000, a}; endfunction
  function automatic logic [15:0] wr(logic [7:0] a); return {3'b110, 2'd0, 3'b000, a}; endfunction
  function automatic logic [15:0] sn(logic [1:0] o, logic [7:0] a); return {3'b001, o, 3'b000, a}; endfunction
  function automatic logic [15:0] fl(logic s, logic [7:0] a); return {3'b000, 2'd0, 1'b1, s, 1'b0, a}; endfunction
  function automatic logic [15:0] ak(logic [7:0] a); return {3'b000, 2'd0, 3'b001, a}; endfunction
  function automatic logic [9:0] e_nil(); return 10'd0; endfunction
  function automatic logic [9:0] e_rsp(logic [2:0] s); return {1'b1, s, 1'b0, 2'd0, 3'b000}; endfunction
  function automatic logic [9:0] e_bus(logic [1:0] o); return {1'b0, 3'd0, 1'b1, o, 3'b000}; endfunction
  function automatic logic [9:0] e_bwb(logic [1:0] o); return {1'b0, 3'd0, 1'b1, o, 3'b001}; endfunction
  function automatic logic [9:0] e_snp(logic p, logic f); return {1'b0, 3'd0, 1'b0, 2'd0, p, f, 1'b0}; endfunction

  localparam int NV = 44;
  localparam logic [25:0] VEC [NV] = '{
    {rd(8'h10), e_bus(2'd0)},      {fl(1'b0, 8'h10), e_rsp(3'd2)},
    {wr(8'h10), e_rsp(3'd3)},      {sn(2'd0, 8'h10), e_snp(1'b1, 1'b1)},
    {rd(8'h10), e_rsp(3'd1)},      {wr(8'h10), e_bus(2'd2)},
    {ak(8'h10), e_rsp(3'd3)},      {sn(2'd1, 8'h10), e_snp(1'b1, 1'b1)},
    {rd(8'h10), e_bus(2'd0)},      {fl(1'b1, 8'h10), e_rsp(3'd1)},
    {sn(2'd2, 8'h10), e_nil()},    {rd(8'h10), e_bus(2'd0)},
    {fl(1'b0, 8'h10), e_rsp(3'd2)}, {sn(2'd0, 8'h10), e_snp(1'b1, 1'b0)},
    {rd(8'h10), e_rsp(3'd1)},      {sn(2'd1, 8'h11), e_nil()},
    {sn(2'd0, 8'h14), e_nil()},    {rd(8'h10), e_rsp(3'd1)},
    {wr(8'h21), e_bus(2'd1)},      {fl(1'b0, 8'h21), e_rsp(3'd3)},
    {sn(2'd0, 8'h21), e_snp(1'b1, 1'b1)}, {rd(8'h32), e_bus(2'd0)},
    {sn(2'd1, 8'h32), e_nil()},    {fl(1'b0, 8'h32), e_rsp(3'd0)},
    {rd(8'h32), e_bus(2'd0)},      {fl(1'b1, 8'h32), e_rsp(3'd1)},
    {wr(8'h32), e_bus(2'd2)},      {sn(2'd2, 8'h32), e_nil()},
    {ak(8'h32), e_bus(2'd1)},      {fl(1'b0, 8'h32), e_rsp(3'd3)},
    {rd(8'h32), e_rsp(3'd3)},      {rd(8'h36), e_bwb(2'd0)},
    {fl(1'b0, 8'h36), e_rsp(3'd2)}, {rd(8'h32), e_bus(2'd0)},
    {fl(1'b1, 8'h32), e_rsp(3'd1)}, {wr(8'h03), e_bus(2'd1)},
    {sn(2'd0, 8'h03), e_nil()},    {fl(1'b0, 8'h03), e_rsp(3'd3)},
    {sn(2'd1, 8'h03), e_snp(1'b1, 1'b1)}, {sn(2'd0, 8'h10), e_nil()},
    {rd(8'h10), e_rsp(3'd1)},      {sn(2'd1, 8'h10), e_nil()},
    {rd(8'h10), e_bus(2'd0)},      {fl(1'b0, 8'h10), e_rsp(3'd2)}
  };

  function automatic string req_of(int i);
    if (i <= 1 || i == 8 || i == 9 || i == 11 || i == 12 || i == 21) return "R2";
    if (i == 2 || i == 4 || i == 14 || i == 30) return "R5";
    if (i == 3 || i == 13 || i == 20 || i == 39 || i == 40) return "R6";
    if (i == 5 || i == 6) return "R4";
    if (i == 7 || i == 10 || i == 38 || i >= 41) return "R7";
    if ((i >= 15 && i <= 17) || (i >= 35 && i <= 37)) return "R8";
    if (i == 18 || i == 19) return "R3";
    if (i >= 22 && i <= 25) return "R9";
    if (i >= 26 && i <= 29) return "R10";
    return "R12";
  endfunction

  task automatic check(bit ok, string rq, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic idle();
    {cpu_req_valid, cpu_req_write, snp_valid, bus_fill_valid, bus_fill_shared, bus_ack_done} = '0;
  endtask

  task automatic drive(logic [15:0] s);
    {cpu_req_valid, cpu_req_write, snp_valid, snp_op,
     bus_fill_valid, bus_fill_shared, bus_ack_done} = s[15:8];
    cpu_req_addr = s[7:0];
    snp_addr     = s[7:0];
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  function automatic logic [9:0] observed();
    return {cpu_resp_valid, cpu_resp_valid ? cpu_resp_state : 3'd0,
            bus_req_valid, bus_req_valid ? bus_req_op : 2'd0,
            snp_supply, snp_flush, wb_valid};
  endfunction

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check(cpu_req_ready === 1'b1, "R1", 32'(cpu_req_ready), 32'd1);
    check({cpu_resp_valid, bus_req_valid, snp_supply, snp_flush, wb_valid} === 5'd0, "R1",
          32'({cpu_resp_valid, bus_req_valid, snp_supply, snp_flush, wb_valid}), 32'd0);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][25:10]);
      check(observed() === VEC[i][9:0], req_of(i), 32'(observed()), 32'(VEC[i][9:0]));
      if (VEC[i][6])
        check(bus_req_addr === VEC[i][17:10], req_of(i), 32'(bus_req_addr), 32'(VEC[i][17:10]));
    end

    // R11: stall while a miss is pending; held request issues nothing
    drive(rd(8'h05));
    check(bus_req_valid === 1'b1, "R11", 32'(bus_req_valid), 32'd1);
    for (int k = 0; k < 3; k++) begin
      cpu_req_valid = 1'b1; cpu_req_write = 1'b1; cpu_req_addr = 8'h09;
      #1;
      check(cpu_req_ready === 1'b0, "R11", 32'(cpu_req_ready), 32'd0);
      @(posedge clk); @(negedge clk);
      check({bus_req_valid, cpu_resp_valid} === 2'b00, "R11",
            32'({bus_req_valid, cpu_resp_valid}), 32'd0);
    end
    drive(fl(1'b0, 8'h05));
    check(cpu_resp_valid === 1'b1 && cpu_resp_state === 3'd2, "R11",
          32'({cpu_resp_valid, cpu_resp_state}), 32'h0a);

    // R11: a snoop in the same cycle blocks acceptance
    cpu_req_valid = 1'b1; cpu_req_addr = 8'h09; cpu_req_write = 1'b0;
    snp_valid = 1'b1; snp_op = 2'd0; snp_addr = 8'h3f;
    #1;
    check(cpu_req_ready === 1'b0, "R11", 32'(cpu_req_ready), 32'd0);
    @(posedge clk); @(negedge clk);
    idle();
    check(bus_req_valid === 1'b0, "R11", 32'(bus_req_valid), 32'd0);
    drive(rd(8'h09));
    check(bus_req_valid === 1'b1 && bus_req_addr === 8'h09, "R11",
          32'({bus_req_valid, bus_req_addr}), 32'h109);
    drive(fl(1'b1, 8'h09));

    // R12: dirty victim write-back carries the old address
    drive(wr(8'h32));
    drive(ak(8'h32));
    check(cpu_resp_state === 3'd3, "R12", 32'(cpu_resp_state), 32'd3);
    drive(rd(8'h3a));
    check(wb_valid === 1'b1 && wb_addr === 8'h32, "R12",
          32'({wb_valid, wb_addr}), 32'h132);
    check(bus_req_addr === 8'h3a, "R12", 32'(bus_req_addr), 32'h3a);
    drive(fl(1'b0, 8'h3a));

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule